// File: doc/BRIEF.md
# Neighbour-Shared Local Data Memory

This block holds the local data memory of one processing element in a two-dimensional mesh and steers every access into it. The memory is a true dual-port array of 32-bit words. The first port belongs to the owning element. The second port is shared by the element's southern and eastern neighbours, which read and write this memory directly instead of copying blocks of data between elements. Seen from any element, the memories of its western and northern neighbours are reached in this way.

The second port also carries a start-up loading path. While the load enable is high, that path owns the port and both neighbours are held off. When the two neighbours ask in the same cycle, a round-robin arbiter picks one and holds the other with a wait signal. An element at the head of a row can also be built with a row-bus path on the first port. That path takes precedence over the local element.

Top module: `ldm_shared_mem`

## Requirements
- R1: During and right after reset, `a_rvalid`, `rb_rvalid`, `s_rvalid` and `e_rvalid` are low. The first south/east conflict after reset is won by south.
- R2: A local access with `a_en` high and `a_wait` low writes `a_wdata` at `a_addr` in that cycle when `a_we` is 1. When `a_we` is 0, it returns the word on `a_rdata` with `a_rvalid` high one cycle later.
- R3: A lone neighbour request (`s_req` or `e_req`) is granted at once and its wait output stays low. A granted write completes in that cycle. A granted read returns the word on `b_rdata` one cycle later, with that requester's own valid (`s_rvalid` or `e_rvalid`) high.
- R4: When south and east request together, exactly one is granted and the other sees its wait high, and its access has no effect. After every grant, the other requester is favoured at the next conflict.
- R5: While `init_en` is high, both neighbour requests are held with wait high and change nothing. A cycle with `init_valid` high writes `init_wdata` at `init_addr`. Load cycles leave the round-robin favour unchanged.
- R6: A write through the first port and a write through the second port to the same address in the same cycle leave the first port's data in memory.
- R7: A read on one port of an address that the other port writes in the same cycle returns the word held before that cycle.
- R8: With `ROW_HEAD` = 1, a row-bus request `rb_req` owns the first port. It writes when `rb_we` = 1. When `rb_we` = 0, it reads onto `a_rdata` with `rb_rvalid` high one cycle later. A local request in the same cycle sees `a_wait` high and has no effect. With `ROW_HEAD` = 0, the row-bus inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_en | input | 1 | Local element access request |
| a_we | input | 1 | Local access is a write |
| a_addr | input | AW | Local word address |
| a_wdata | input | DW | Local write data |
| a_wait | output | 1 | Local request held this cycle |
| a_rvalid | output | 1 | Local read data valid on `a_rdata` |
| rb_req | input | 1 | Row-bus access request (row head only) |
| rb_we | input | 1 | Row-bus access is a write |
| rb_addr | input | AW | Row-bus word address |
| rb_wdata | input | DW | Row-bus write data |
| rb_rvalid | output | 1 | Row-bus read data valid on `a_rdata` |
| a_rdata | output | DW | First-port read data |
| init_en | input | 1 | Start-up load owns the second port |
| init_valid | input | 1 | Load word present this cycle |
| init_addr | input | AW | Load word address |
| init_wdata | input | DW | Load word data |
| s_req | input | 1 | South neighbour request |
| s_we | input | 1 | South access is a write |
| s_addr | input | AW | South word address |
| s_wdata | input | DW | South write data |
| s_wait | output | 1 | South request held this cycle |
| s_rvalid | output | 1 | South read data valid on `b_rdata` |
| e_req | input | 1 | East neighbour request |
| e_we | input | 1 | East access is a write |
| e_addr | input | AW | East word address |
| e_wdata | input | DW | East write data |
| e_wait | output | 1 | East request held this cycle |
| e_rvalid | output | 1 | East read data valid on `b_rdata` |
| b_rdata | output | DW | Second-port read data |

## Verification
Every address of a 16-word configuration is written with an address-derived pattern through each path in turn: local, south, east, load and row bus. Each word is then read back through a different path, which tells a mis-steered address or data mux apart from a faulty array. Request patterns of both, south only and east only are cycled against a bench model of the favour bit, with both requesters aimed at one address. The surviving word therefore shows which access won and that the loser wrote nothing. Same-address write pairs and read-against-write pairs on every address separate first-port priority from read-before-write ordering.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

    // Which neighbour wins the next south/east conflict
    typedef enum logic {
        FAV_SOUTH = 1'b0,
        FAV_EAST  = 1'b1
    } fav_e;

    // Current owner of the shared second port
    typedef enum logic [1:0] {
        BSRC_IDLE  = 2'd0,
        BSRC_INIT  = 2'd1,
        BSRC_SOUTH = 2'd2,
        BSRC_EAST  = 2'd3
    } bsrc_e;

    typedef struct packed {
        fav_e fav;
    } arb_state_t;

    typedef struct packed {
        logic loc;
        logic row;
        logic sth;
        logic est;
    } rvalid_t;

endpackage

// File: rtl/ldm_rr_arb.sv
module ldm_rr_arb
    import ldm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  init_en,
    input  logic  s_req,
    input  logic  e_req,
    output logic  s_gnt,
    output logic  e_gnt,
    output bsrc_e src
);

    arb_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        s_gnt = 1'b0;
        e_gnt = 1'b0;
        src   = BSRC_IDLE;
        if (init_en) begin
            // loading owns the port; favour is frozen
            src = BSRC_INIT;
        end else if (s_req && e_req) begin
            if (st_q.fav == FAV_SOUTH) s_gnt = 1'b1;
            else                       e_gnt = 1'b1;
        end else begin
            s_gnt = s_req;
            e_gnt = e_req;
        end
        if (s_gnt) begin
            src      = BSRC_SOUTH;
            st_d.fav = FAV_EAST;
        end
        if (e_gnt) begin
            src      = BSRC_EAST;
            st_d.fav = FAV_SOUTH;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{fav: FAV_SOUTH};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ldm_bport_mux.sv
module ldm_bport_mux
    import ldm_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 11
) (
    input  bsrc_e          src,
    input  logic           init_valid,
    input  logic [AW-1:0]  init_addr,
    input  logic [DW-1:0]  init_wdata,
    input  logic           s_we,
    input  logic [AW-1:0]  s_addr,
    input  logic [DW-1:0]  s_wdata,
    input  logic           e_we,
    input  logic [AW-1:0]  e_addr,
    input  logic [DW-1:0]  e_wdata,
    output logic           b_en,
    output logic           b_we,
    output logic [AW-1:0]  b_addr,
    output logic [DW-1:0]  b_wdata
);

    always_comb begin
        b_en    = 1'b0;
        b_we    = 1'b0;
        b_addr  = '0;
        b_wdata = '0;
        unique case (src)
            BSRC_INIT: begin
                b_en    = init_valid;
                b_we    = 1'b1;
                b_addr  = init_addr;
                b_wdata = init_wdata;
            end
            BSRC_SOUTH: begin
                b_en    = 1'b1;
                b_we    = s_we;
                b_addr  = s_addr;
                b_wdata = s_wdata;
            end
            BSRC_EAST: begin
                b_en    = 1'b1;
                b_we    = e_we;
                b_addr  = e_addr;
                b_wdata = e_wdata;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ldm_aport_sel.sv
module ldm_aport_sel #(
    parameter int unsigned DW       = 32,
    parameter int unsigned AW       = 11,
    parameter bit          ROW_HEAD = 1'b0
) (
    input  logic           a_en,
    input  logic           a_we,
    input  logic [AW-1:0]  a_addr,
    input  logic [DW-1:0]  a_wdata,
    input  logic           rb_req,
    input  logic           rb_we,
    input  logic [AW-1:0]  rb_addr,
    input  logic [DW-1:0]  rb_wdata,
    output logic           m_en,
    output logic           m_we,
    output logic [AW-1:0]  m_addr,
    output logic [DW-1:0]  m_wdata,
    output logic           a_gnt,
    output logic           rb_gnt
);

    generate
        if (ROW_HEAD) begin : g_row_head
            // row bus pre-empts the local element
            always_comb begin
                rb_gnt = rb_req;
                a_gnt  = a_en && !rb_req;
                if (rb_req) begin
                    m_en    = 1'b1;
                    m_we    = rb_we;
                    m_addr  = rb_addr;
                    m_wdata = rb_wdata;
                end else begin
                    m_en    = a_en;
                    m_we    = a_we;
                    m_addr  = a_addr;
                    m_wdata = a_wdata;
                end
            end
        end else begin : g_plain
            logic unused_rowbus;
            assign unused_rowbus = ^{rb_req, rb_we, rb_addr, rb_wdata};
            assign rb_gnt  = 1'b0;
            assign a_gnt   = a_en;
            assign m_en    = a_en;
            assign m_we    = a_we;
            assign m_addr  = a_addr;
            assign m_wdata = a_wdata;
        end
    endgenerate

endmodule

// File: rtl/ldm_dpram.sv
module ldm_dpram #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 11
) (
    input  logic           clk,
    input  logic           a_en,
    input  logic           a_we,
    input  logic [AW-1:0]  a_addr,
    input  logic [DW-1:0]  a_wdata,
    output logic [DW-1:0]  a_rdata,
    input  logic           b_en,
    input  logic           b_we,
    input  logic [AW-1:0]  b_addr,
    input  logic [DW-1:0]  b_wdata,
    output logic [DW-1:0]  b_rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Second-port write is issued first so a same-address first-port
    // write in the same cycle overrides it. Reads see pre-edge contents.
    always_ff @(posedge clk) begin
        if (b_en && b_we) mem_q[b_addr] <= b_wdata;
        if (a_en && a_we) mem_q[a_addr] <= a_wdata;
        if (a_en && !a_we) a_rdata <= mem_q[a_addr];
        if (b_en && !b_we) b_rdata <= mem_q[b_addr];
    end

endmodule

// File: rtl/ldm_shared_mem.sv
module ldm_shared_mem
    import ldm_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter int unsigned AW       = 11,
    parameter bit          ROW_HEAD = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           a_en,
    input  logic           a_we,
    input  logic [AW-1:0]  a_addr,
    input  logic [DW-1:0]  a_wdata,
    output logic           a_wait,
    output logic           a_rvalid,
    input  logic           rb_req,
    input  logic           rb_we,
    input  logic [AW-1:0]  rb_addr,
    input  logic [DW-1:0]  rb_wdata,
    output logic           rb_rvalid,
    output logic [DW-1:0]  a_rdata,
    input  logic           init_en,
    input  logic           init_valid,
    input  logic [AW-1:0]  init_addr,
    input  logic [DW-1:0]  init_wdata,
    input  logic           s_req,
    input  logic           s_we,
    input  logic [AW-1:0]  s_addr,
    input  logic [DW-1:0]  s_wdata,
    output logic           s_wait,
    output logic           s_rvalid,
    input  logic           e_req,
    input  logic           e_we,
    input  logic [AW-1:0]  e_addr,
    input  logic [DW-1:0]  e_wdata,
    output logic           e_wait,
    output logic           e_rvalid,
    output logic [DW-1:0]  b_rdata
);

    logic          s_gnt, e_gnt, a_gnt, rb_gnt;
    bsrc_e         bsrc;
    logic          ma_en, ma_we, mb_en, mb_we;
    logic [AW-1:0] ma_addr, mb_addr;
    logic [DW-1:0] ma_wdata, mb_wdata;
    rvalid_t       vld_d, vld_q;

    ldm_rr_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_en (init_en),
        .s_req   (s_req),
        .e_req   (e_req),
        .s_gnt   (s_gnt),
        .e_gnt   (e_gnt),
        .src     (bsrc)
    );

    ldm_bport_mux #(.DW(DW), .AW(AW)) u_bmux (
        .src        (bsrc),
        .init_valid (init_valid),
        .init_addr  (init_addr),
        .init_wdata (init_wdata),
        .s_we       (s_we),
        .s_addr     (s_addr),
        .s_wdata    (s_wdata),
        .e_we       (e_we),
        .e_addr     (e_addr),
        .e_wdata    (e_wdata),
        .b_en       (mb_en),
        .b_we       (mb_we),
        .b_addr     (mb_addr),
        .b_wdata    (mb_wdata)
    );

    ldm_aport_sel #(.DW(DW), .AW(AW), .ROW_HEAD(ROW_HEAD)) u_asel (
        .a_en     (a_en),
        .a_we     (a_we),
        .a_addr   (a_addr),
        .a_wdata  (a_wdata),
        .rb_req   (rb_req),
        .rb_we    (rb_we),
        .rb_addr  (rb_addr),
        .rb_wdata (rb_wdata),
        .m_en     (ma_en),
        .m_we     (ma_we),
        .m_addr   (ma_addr),
        .m_wdata  (ma_wdata),
        .a_gnt    (a_gnt),
        .rb_gnt   (rb_gnt)
    );

    ldm_dpram #(.DW(DW), .AW(AW)) u_ram (
        .clk     (clk),
        .a_en    (ma_en),
        .a_we    (ma_we),
        .a_addr  (ma_addr),
        .a_wdata (ma_wdata),
        .a_rdata (a_rdata),
        .b_en    (mb_en),
        .b_we    (mb_we),
        .b_addr  (mb_addr),
        .b_wdata (mb_wdata),
        .b_rdata (b_rdata)
    );

    always_comb begin
        vld_d     = '0;
        vld_d.loc = a_gnt  && !a_we;
        vld_d.row = rb_gnt && !rb_we;
        vld_d.sth = s_gnt  && !s_we;
        vld_d.est = e_gnt  && !e_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    assign a_wait    = a_en  && !a_gnt;
    assign s_wait    = s_req && !s_gnt;
    assign e_wait    = e_req && !e_gnt;
    assign a_rvalid  = vld_q.loc;
    assign rb_rvalid = vld_q.row;
    assign s_rvalid  = vld_q.sth;
    assign e_rvalid  = vld_q.est;

endmodule

// File: rtl/ldm_shared_mem_chk.sv
module ldm_shared_mem_chk #(
    parameter bit ROW_HEAD = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic a_en,
    input logic a_we,
    input logic a_wait,
    input logic a_rvalid,
    input logic rb_req,
    input logic rb_we,
    input logic rb_rvalid,
    input logic init_en,
    input logic s_req,
    input logic s_we,
    input logic s_wait,
    input logic s_rvalid,
    input logic e_req,
    input logic e_we,
    input logic e_wait,
    input logic e_rvalid
);

    // R2: granted local read returns valid next cycle
    p_local_read_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_wait && !a_we) |=> a_rvalid);

    // R3: granted south read returns valid next cycle, and only then
    p_south_read_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && !s_wait && !s_we) |=> s_rvalid);
    p_south_valid_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> $past(s_req && !s_wait && !s_we));
    p_east_read_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (e_req && !e_wait && !e_we) |=> e_rvalid);

    // R4: a conflict has exactly one loser
    p_one_loser_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && e_req && !init_en) |-> (s_wait != e_wait));
    // R4: back-to-back conflicts alternate
    p_alternate_s_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && e_req && !init_en && $past(s_req && e_req && !init_en && !s_wait))
        |-> s_wait);
    p_alternate_e_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && e_req && !init_en && $past(s_req && e_req && !init_en && !e_wait))
        |-> e_wait);

    // R5: loading holds both neighbours
    p_init_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_en |-> ((s_wait == s_req) && (e_wait == e_req)));

    generate
        if (ROW_HEAD) begin : g_row
            // R8: row bus pre-empts the local element
            p_row_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (rb_req && a_en) |-> a_wait);
            p_row_read_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (rb_req && !rb_we) |=> (rb_rvalid && !a_rvalid));
        end else begin : g_norow
            // R8: without a row head the row path never answers
            p_row_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !rb_rvalid && !a_wait);
        end
    endgenerate

endmodule

bind ldm_shared_mem ldm_shared_mem_chk #(.ROW_HEAD(ROW_HEAD)) u_chk (.*);

// File: tb/ldm_shared_mem_tb.sv
module ldm_shared_mem_tb;

    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_en = 0, a_we = 0, rb_req = 0, rb_we = 0;
    logic init_en = 0, init_valid = 0;
    logic s_req = 0, s_we = 0, e_req = 0, e_we = 0;
    logic [AW-1:0] a_addr = '0, rb_addr = '0, init_addr = '0, s_addr = '0, e_addr = '0;
    logic [DW-1:0] a_wdata = '0, rb_wdata = '0, init_wdata = '0, s_wdata = '0, e_wdata = '0;
    logic a_wait, a_rvalid, rb_rvalid, s_wait, s_rvalid, e_wait, e_rvalid;
    logic [DW-1:0] a_rdata, b_rdata;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;
    logic [DW-1:0] mdl [NW];
    bit  fav_s = 1;   // bench model: south wins next conflict

    always #5 clk = ~clk;

    ldm_shared_mem #(.DW(DW), .AW(AW), .ROW_HEAD(1'b1)) u_dut (.*);

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        a_en = 0; a_we = 0; rb_req = 0; rb_we = 0;
        init_en = 0; init_valid = 0;
        s_req = 0; s_we = 0; e_req = 0; e_we = 0;
    endtask

    task automatic rd_a(input int ad, input string tag);
        a_en = 1; a_we = 0; a_addr = AW'(ad);
        step();
        check({tag, " a_rvalid"}, 32'(a_rvalid), 32'd1);
        check({tag, " a_rdata"}, a_rdata, mdl[ad]);
        idle();
    endtask

    task automatic rd_s(input int ad, input string tag);
        s_req = 1; s_we = 0; s_addr = AW'(ad);
        #1 check({tag, " s_wait"}, 32'(s_wait), 32'd0);
        step();
        check({tag, " s_rvalid"}, 32'(s_rvalid), 32'd1);
        check({tag, " b_rdata"}, b_rdata, mdl[ad]);
        idle();
        fav_s = 0;
    endtask

    task automatic rd_e(input int ad, input string tag);
        e_req = 1; e_we = 0; e_addr = AW'(ad);
        #1 check({tag, " e_wait"}, 32'(e_wait), 32'd0);
        step();
        check({tag, " e_rvalid"}, 32'(e_rvalid), 32'd1);
        check({tag, " b_rdata"}, b_rdata, mdl[ad]);
        idle();
        fav_s = 1;
    endtask

    initial begin
        // R1: reset state
        repeat (3) step();
        check("R1 a_rvalid", 32'(a_rvalid), 0);
        check("R1 rb_rvalid", 32'(rb_rvalid), 0);
        check("R1 s_rvalid", 32'(s_rvalid), 0);
        check("R1 e_rvalid", 32'(e_rvalid), 0);
        rst_n = 1;
        step();

        // R2: local writes, local reads
        for (int i = 0; i < NW; i++) begin
            a_en = 1; a_we = 1; a_addr = AW'(i);
            a_wdata = 32'h1000_0000 + 32'(i) * 32'h0101_0101;
            step();
            mdl[i] = a_wdata;
            idle();
        end
        for (int i = 0; i < NW; i++) rd_a(i, "R2");

        // R3: lone neighbour reads and writes
        for (int i = 0; i < NW; i++) rd_s(i, "R3 south rd");
        for (int i = 0; i < NW; i++) begin
            if (i % 2 == 0) begin
                s_req = 1; s_we = 1; s_addr = AW'(i); s_wdata = 32'h2000_0000 + 32'(i);
                #1 check("R3 s_wait on write", 32'(s_wait), 0);
                fav_s = 0;
            end else begin
                e_req = 1; e_we = 1; e_addr = AW'(i); e_wdata = 32'h3000_0000 + 32'(i);
                #1 check("R3 e_wait on write", 32'(e_wait), 0);
                fav_s = 1;
            end
            step();
            mdl[i] = (i % 2 == 0) ? 32'h2000_0000 + 32'(i) : 32'h3000_0000 + 32'(i);
            idle();
        end
        for (int i = 0; i < NW; i++) rd_e(i, "R3 east rd");
        for (int i = 0; i < NW; i++) rd_a(i, "R3 via local");

        // R1/R4: conflict patterns against the favour model
        fav_s = 1;   // last lone grant above went to east
        for (int k = 0; k < NW; k++) begin
            bit sr, er, sw;
            sr = (k % 4) != 3;
            er = (k % 4) != 2;
            sw = sr && (!er || fav_s);
            s_req = sr; s_we = 1; s_addr = AW'(k); s_wdata = 32'h5000_0000 + 32'(k);
            e_req = er; e_we = 1; e_addr = AW'(k); e_wdata = 32'h6000_0000 + 32'(k);
            #1;
            check("R4 s_wait", 32'(s_wait), 32'(sr && !sw));
            check("R4 e_wait", 32'(e_wait), 32'(er && sw));
            step();
            mdl[k] = sw ? 32'h5000_0000 + 32'(k) : 32'h6000_0000 + 32'(k);
            fav_s = !sw;
            idle();
            rd_a(k, "R4 winner data");
        end

        // R5: load path owns the second port
        for (int i = 0; i < NW; i++) begin
            init_en = 1; init_valid = 1; init_addr = AW'(i);
            init_wdata = 32'h7000_0000 + 32'(i);
            s_req = 1; s_we = 1; s_addr = AW'((i + 5) % NW); s_wdata = 32'hDEAD_0000;
            e_req = 1; e_we = 1; e_addr = AW'((i + 9) % NW); e_wdata = 32'hBEEF_0000;
            #1;
            check("R5 s_wait", 32'(s_wait), 1);
            check("R5 e_wait", 32'(e_wait), 1);
            step();
            mdl[i] = 32'h7000_0000 + 32'(i);
        end
        init_valid = 0;
        step();       // neighbours still held, no load word
        idle();
        for (int i = 0; i < NW; i++) rd_a(i, "R5 loaded data");
        begin
            bit sw;
            sw = fav_s;
            s_req = 1; s_we = 1; s_addr = 0; s_wdata = 32'h5555_5555;
            e_req = 1; e_we = 1; e_addr = 0; e_wdata = 32'h6666_6666;
            #1 check("R5 favour kept", 32'(s_wait), 32'(!sw));
            step();
            mdl[0] = sw ? 32'h5555_5555 : 32'h6666_6666;
            fav_s = !sw;
            idle();
            rd_a(0, "R5 favour kept data");
        end

        // R6: same-address writes on both ports
        for (int i = 0; i < NW; i++) begin
            a_en = 1; a_we = 1; a_addr = AW'(i); a_wdata = 32'hA000_0000 + 32'(i);
            if (i % 2 == 0) begin
                s_req = 1; s_we = 1; s_addr = AW'(i); s_wdata = 32'hB000_0000 + 32'(i);
                fav_s = 0;
            end else begin
                e_req = 1; e_we = 1; e_addr = AW'(i); e_wdata = 32'hC000_0000 + 32'(i);
                fav_s = 1;
            end
            step();
            mdl[i] = 32'hA000_0000 + 32'(i);
            idle();
        end
        for (int i = 0; i < NW; i++) rd_e(i, "R6 first port wins");

        // R7: read-before-write across ports
        for (int i = 0; i < NW; i++) begin
            a_en = 1; a_we = 1; a_addr = AW'(i); a_wdata = 32'hD000_0000 + 32'(i);
            s_req = 1; s_we = 0; s_addr = AW'(i);
            step();
            check("R7 b old word", b_rdata, mdl[i]);
            mdl[i] = 32'hD000_0000 + 32'(i);
            fav_s = 0;
            idle();
            e_req = 1; e_we = 1; e_addr = AW'(i); e_wdata = 32'hE000_0000 + 32'(i);
            a_en = 1; a_we = 0; a_addr = AW'(i);
            step();
            check("R7 a old word", a_rdata, mdl[i]);
            mdl[i] = 32'hE000_0000 + 32'(i);
            fav_s = 1;
            idle();
        end
        for (int i = 0; i < NW; i++) rd_s(i, "R7 final");

        // R8: row bus pre-empts local element
        for (int i = 0; i < NW; i++) begin
            rb_req = 1; rb_we = 1; rb_addr = AW'(i); rb_wdata = 32'h9000_0000 + 32'(i);
            a_en = 1; a_we = 1; a_addr = AW'(i); a_wdata = 32'hFFFF_0000;
            #1 check("R8 a_wait", 32'(a_wait), 1);
            step();
            mdl[i] = 32'h9000_0000 + 32'(i);
            idle();
        end
        for (int i = 0; i < NW; i++) begin
            rb_req = 1; rb_we = 0; rb_addr = AW'(i);
            a_en = 1; a_we = 0; a_addr = AW'((i + 1) % NW);
            step();
            check("R8 rb_rvalid", 32'(rb_rvalid), 1);
            check("R8 a_rvalid held", 32'(a_rvalid), 0);
            check("R8 rb data", a_rdata, mdl[i]);
            idle();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule